// File: doc/BRIEF.md
# Conditional Branch and Call Resolver

This block settles the control-flow side of a branch or subroutine-call instruction in a 16-bit processor. The decode stage supplies an issue strobe and several inputs: the eight-bit status flag field, a three-bit condition select and an invert bit. It also supplies two kind bits (relative or absolute, call or plain jump), the already-fetched target or offset word, the current program counter and the stack pointer. One cycle after the strobe, the block reports whether the transfer is taken and what the next program counter is. For a taken call, it also issues a one-word stack write and reports the new stack pointer.

The program counter input is expected to already point past the branch instruction and its operand word. That same value is both the base for relative targets and the return address a call pushes. Returns are expected to be done elsewhere, as a load of the program counter from the stack with post-increment of the stack pointer, so a call pushes with pre-decrement. The stored status register is never modified by this block. Inverting the condition only affects this one decision.

Top module: `cond_branch_unit`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, before any issue, all outputs are zero.
- R2: Condition select chooses a flag bit by index. Index 0 always reads as 1, whatever flags[0] is. Indices 1 to 5 read flags[1] to flags[5] (X, C, Z, N, V). Indices 6 and 7 always read as 0.
- R3: With cond_neg high, the complement of the selected flag decides the transfer. The flags input is not written back in any form.
- R4: A taken transfer with is_rel low sets pc_next to operand.
- R5: A taken transfer with is_rel high sets pc_next to pc plus operand, modulo 2^16. Negative offsets are two's complement.
- R6: A transfer that is not taken gives pc_next equal to pc, sp_next equal to sp, and no stack write, whatever the kind bits are.
- R7: A taken transfer with is_call high raises stk_we for one cycle, with stk_addr equal to sp minus 1 (modulo 2^16) and stk_data equal to pc. sp_next equals that same address.
- R8: A taken transfer with is_call low makes no stack write and leaves sp_next equal to sp.
- R9: Results appear in the cycle after an issue (req high at a rising edge), together with a one-cycle done pulse. In cycles without an issue, done, taken and stk_we are low, and pc_next, sp_next, stk_addr and stk_data keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Issue strobe for one branch or call |
| flags | input | 8 | Status flag field |
| cond_sel | input | 3 | Index of the flag to test |
| cond_neg | input | 1 | Test the complement of the selected flag |
| is_rel | input | 1 | 1: target is pc + operand; 0: target is operand |
| is_call | input | 1 | 1: push the return address when taken |
| operand | input | 16 | Absolute target or relative offset |
| pc | input | 16 | Program counter, already past the operand word |
| sp | input | 16 | Current stack pointer |
| done | output | 1 | Result valid, one cycle after req |
| taken | output | 1 | Transfer taken |
| pc_next | output | 16 | Next program counter |
| sp_next | output | 16 | Stack pointer after the instruction |
| stk_we | output | 1 | Stack write enable |
| stk_addr | output | 16 | Stack write address |
| stk_data | output | 16 | Stack write data (return address) |

## Verification
The assertions are checked on every cycle. They cover the one-cycle issue-to-result timing and the rule that a stack write happens only with a result, at the address reported as the new stack pointer. They also check the untaken case, where the program counter and stack pointer pass through, and that a taken call pushes the issued pc. Some behaviour only the bench's scenarios can show. This includes the flag indexing, the forced constant bits 0, 6 and 7, the inversion, relative wrap-around and the stack pointer wrapping below zero. It also includes the held outputs between issues, all of which need chosen flag and operand values.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int W = 16,
  parameter int NFLAG = 8,
  parameter logic [NFLAG-1:0] LIVE_MASK = 8'h3E,
  localparam int SELW = $clog2(NFLAG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [NFLAG-1:0] flags,
  input  logic [SELW-1:0] cond_sel,
  input  logic            cond_neg,
  input  logic            is_rel,
  input  logic            is_call,
  input  logic [W-1:0]    operand,
  input  logic [W-1:0]    pc,
  input  logic [W-1:0]    sp,
  output logic            done,
  output logic            taken,
  output logic [W-1:0]    pc_next,
  output logic [W-1:0]    sp_next,
  output logic            stk_we,
  output logic [W-1:0]    stk_addr,
  output logic [W-1:0]    stk_data
);

  logic [NFLAG-1:0] eff_flags;
  logic             go;
  logic [W-1:0]     target;
  logic [W-1:0]     push_addr;

  assign eff_flags = (flags & LIVE_MASK) | NFLAG'(1);
  assign go        = eff_flags[cond_sel] ^ cond_neg;
  assign target    = is_rel ? pc + operand : operand;
  assign push_addr = sp - W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      taken    <= 1'b0;
      pc_next  <= '0;
      sp_next  <= '0;
      stk_we   <= 1'b0;
      stk_addr <= '0;
      stk_data <= '0;
    end else begin
      done   <= req;
      taken  <= req & go;
      stk_we <= req & go & is_call;
      if (req) begin
        pc_next  <= go ? target : pc;
        sp_next  <= (go && is_call) ? push_addr : sp;
        stk_addr <= push_addr;
        stk_data <= pc;
      end
    end
  end

endmodule

module cond_branch_unit_chk #(
  parameter int W = 16,
  parameter int NFLAG = 8,
  localparam int SELW = $clog2(NFLAG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            is_call,
  input logic [W-1:0]    pc,
  input logic [W-1:0]    sp,
  input logic            done,
  input logic            taken,
  input logic [W-1:0]    pc_next,
  input logic [W-1:0]    sp_next,
  input logic            stk_we,
  input logic [W-1:0]    stk_addr,
  input logic [W-1:0]    stk_data
);

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req));

  // R9
  write_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we || taken) |-> done);

  // R7
  push_addr_is_new_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> (stk_addr == sp_next && sp_next == $past(sp) - W'(1)));

  // R7
  call_pushes_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && taken && $past(is_call)) |-> (stk_we && stk_data == $past(pc)));

  // R6
  untaken_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !taken) |-> (!stk_we && pc_next == $past(pc) && sp_next == $past(sp)));

  // R8
  jump_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(is_call)) |-> (!stk_we && sp_next == $past(sp)));

endmodule

bind cond_branch_unit cond_branch_unit_chk #(.W(W), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_call(is_call), .pc(pc), .sp(sp),
  .done(done), .taken(taken), .pc_next(pc_next), .sp_next(sp_next),
  .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data)
);

// File: tb/cond_branch_unit_tb.sv
module cond_branch_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  flags = '0;
  logic [2:0]  cond_sel = '0;
  logic        cond_neg = 1'b0, is_rel = 1'b0, is_call = 1'b0;
  logic [15:0] operand = '0, pc = '0, sp = '0;
  logic        done, taken, stk_we;
  logic [15:0] pc_next, sp_next, stk_addr, stk_data;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .flags(flags), .cond_sel(cond_sel),
    .cond_neg(cond_neg), .is_rel(is_rel), .is_call(is_call), .operand(operand),
    .pc(pc), .sp(sp), .done(done), .taken(taken), .pc_next(pc_next),
    .sp_next(sp_next), .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data)
  );

  // stimulus: flags, sel, neg, rel, call, operand, pc, sp
  localparam logic [61:0] STIM [NV] = '{
    {8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0102, 16'h8000},
    {8'h08, 3'd3, 1'b1, 1'b0, 1'b0, 16'h0004, 16'h0102, 16'h8000},
    {8'h00, 3'd3, 1'b1, 1'b0, 1'b0, 16'h0004, 16'h0102, 16'h8000},
    {8'hFF, 3'd6, 1'b0, 1'b0, 1'b0, 16'h0004, 16'h0102, 16'h8000},
    {8'hFF, 3'd7, 1'b1, 1'b1, 1'b0, 16'h0010, 16'h0102, 16'h8000},
    {8'h04, 3'd2, 1'b0, 1'b1, 1'b0, 16'hFFF0, 16'h0005, 16'h8000},
    {8'h10, 3'd4, 1'b0, 1'b0, 1'b1, 16'h2000, 16'h0102, 16'h8000},
    {8'h20, 3'd5, 1'b0, 1'b1, 1'b1, 16'h0100, 16'h0300, 16'h0000},
    {8'h02, 3'd1, 1'b1, 1'b0, 1'b1, 16'h2000, 16'h0102, 16'h8000},
    {8'hFE, 3'd0, 1'b1, 1'b0, 1'b0, 16'h2000, 16'h0102, 16'h8000},
    {8'h01, 3'd1, 1'b0, 1'b0, 1'b0, 16'h2000, 16'h0102, 16'h8000}
  };
  // expected: taken, we, pc_next, sp_next
  localparam logic [33:0] EXP [NV] = '{
    {1'b1, 1'b0, 16'h1234, 16'h8000},
    {1'b0, 1'b0, 16'h0102, 16'h8000},
    {1'b1, 1'b0, 16'h0004, 16'h8000},
    {1'b0, 1'b0, 16'h0102, 16'h8000},
    {1'b1, 1'b0, 16'h0112, 16'h8000},
    {1'b1, 1'b0, 16'hFFF5, 16'h8000},
    {1'b1, 1'b1, 16'h2000, 16'h7FFF},
    {1'b1, 1'b1, 16'h0400, 16'hFFFF},
    {1'b0, 1'b0, 16'h0102, 16'h8000},
    {1'b0, 1'b0, 16'h0102, 16'h8000},
    {1'b0, 1'b0, 16'h0102, 16'h8000}
  };
  localparam string TAG [NV] = '{"R2", "R3", "R3", "R2", "R5", "R5", "R7", "R7", "R6", "R2", "R2"};

  task automatic check(input string req_tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [61:0] s);
    @(negedge clk);
    {flags, cond_sel, cond_neg, is_rel, is_call, operand, pc, sp} = s;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1", "done", 16'(done), 16'h0);
    check("R1", "pc_next", pc_next, 16'h0);
    check("R1", "stk_we", 16'(stk_we), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1", "after release taken", 16'(taken), 16'h0);
    check("R1", "after release sp_next", sp_next, 16'h0);

    for (int i = 0; i < NV; i++) begin
      issue(STIM[i]);
      check("R9", "done", 16'(done), 16'h1);
      check(TAG[i], $sformatf("vec%0d taken", i), 16'(taken), 16'(EXP[i][33]));
      check(TAG[i], $sformatf("vec%0d stk_we", i), 16'(stk_we), 16'(EXP[i][32]));
      check(TAG[i], $sformatf("vec%0d pc_next", i), pc_next, EXP[i][31:16]);
      check(TAG[i], $sformatf("vec%0d sp_next", i), sp_next, EXP[i][15:0]);
      if (EXP[i][32]) begin
        check("R7", $sformatf("vec%0d stk_addr", i), stk_addr, EXP[i][15:0]);
        check("R7", $sformatf("vec%0d stk_data", i), stk_data, STIM[i][31:16]);
      end
    end

    // R4: absolute taken, target independent of pc
    issue({8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h7777, 16'h1000});
    check("R4", "abs target", pc_next, 16'hBEEF);
    // R8: taken jump, no push, sp unchanged
    check("R8", "jump stk_we", 16'(stk_we), 16'h0);
    check("R8", "jump sp_next", sp_next, 16'h1000);

    // R9: call, then idle cycles: pulse drops, values hold
    issue({8'h08, 3'd3, 1'b0, 1'b0, 1'b1, 16'h4000, 16'h0222, 16'h3000});
    check("R7", "call stk_we", 16'(stk_we), 16'h1);
    check("R7", "call stk_addr", stk_addr, 16'h2FFF);
    flags = 8'h00; operand = 16'h0; pc = 16'h5555; sp = 16'h6666;
    @(negedge clk);
    check("R9", "idle done", 16'(done), 16'h0);
    check("R9", "idle taken", 16'(taken), 16'h0);
    check("R9", "idle stk_we", 16'(stk_we), 16'h0);
    check("R9", "idle pc_next hold", pc_next, 16'h4000);
    check("R9", "idle sp_next hold", sp_next, 16'h2FFF);
    check("R9", "idle stk_data hold", stk_data, 16'h0222);
    // R3: inversion leaves the flag input as applied, next test sees plain Z
    issue({8'h08, 3'd3, 1'b0, 1'b0, 1'b0, 16'h0040, 16'h0100, 16'h3000});
    check("R3", "plain Z after negated use", pc_next, 16'h0040);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule